// File: doc/BRIEF.md
# Masked Vector Element Execution Unit

This block is a single-lane vector execution unit. It holds a file of vector registers, a length register and a predicate register. It takes one instruction at a time through a valid/ready handshake and works through the active elements at a rate of one per clock. The arithmetic operates on 64-bit integer elements. Each operation can take its second operand from a vector register or from the scalar field of the instruction. In the scalar form, the same scalar is used for every element.

A strip-mining loop uses the length instruction to cap the element count at the register capacity. The same instruction returns the chosen length, so the controller can count down what is left. A compare instruction fills the predicate, one bit per element. Any element-wise write can then be limited to the elements whose predicate bit is set, by setting a mask bit in that instruction. Three single-cycle instructions give element-level access for loading and inspecting state: insert one element, extract one element, and read the predicate.

Top module: `masked_vector_unit`

## Requirements
- R1: Opcode 0 (set length) writes `vl = min(32, scalar)`, comparing the full 64-bit scalar. It places `vl` zero-extended on `result`, and `done` is high in the cycle after acceptance.
- R2: Opcodes 1, 2 and 3 (vector-vector add, subtract, multiply) write `vd[i] = vs1[i] op vs2[i]` for every active `i < vl`. Add and subtract wrap modulo 2^64. Multiply keeps the low 64 bits of the product.
- R3: Opcodes 4, 5 and 6 (vector-scalar add, subtract, multiply) write `vd[i] = vs1[i] op scalar` for every active `i < vl`, with the same wrap rules as R2. Subtract computes `vs1[i] - scalar`.
- R4: Opcode 7 (compare not-equal) sets predicate bit `i` to 1 when `vs1[i] != scalar` and to 0 otherwise, for `i < vl`. Predicate bits at `vl` and above are left unchanged.
- R5: When the mask bit of an element-writing instruction (opcodes 1 to 6 and 8) is 1, element `i` is written only where predicate bit `i` is 1. Every other element keeps its old value.
- R6: With the mask bit 0, every element below `vl` is written. Elements at index `vl` and above are never written.
- R7: Opcode 8 (splat) writes `vd[i] = scalar` for the active elements.
- R8: Opcode 9 writes `vd[vs2] = scalar`, using the `vs2` field as the element index. Opcode 10 puts `vs1[vs2]` on `result`. Opcode 11 puts the predicate on `result`, with bit `i` at bit position `i` and the upper bits zero. Each of these completes with `done` in the cycle after acceptance.
- R9: An element instruction with `vl > 0` holds `instReady` low for `vl` cycles after acceptance. It then raises `done` for one cycle, together with `instReady`. With `vl = 0`, `done` follows in the next cycle and nothing is written.
- R10: After reset, `instReady` is 1, `done` is 0, `result` is 0, the predicate is all zeros and `vl` is 32.
- R11: Opcodes 12 to 15 change no register, no predicate bit, no length and no `result`. They complete with `done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction offered |
| instOp | input | 4 | Opcode |
| instMask | input | 1 | Limit writes to elements whose predicate bit is set |
| instVd | input | 5 | Destination register |
| instVs1 | input | 5 | First source register |
| instVs2 | input | 5 | Second source register, or element index for opcodes 9 and 10 |
| instScalar | input | 64 | Scalar operand or requested length |
| instReady | output | 1 | Unit idle, instruction accepted when valid |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Scalar result of opcodes 0, 10 and 11 |

## Verification
The bench requests lengths above the capacity, at the capacity, at zero, and with only high bits set. A saturation that compared only the low bits would return a small count instead of 32. Arithmetic cases sit on the 2^64 wrap and the multiply truncation, and one case checks the operand order of scalar subtract. A swapped or widened datapath would give a wrong element there.

The predicate is written twice, at two different lengths. The second compare must leave the bits above the shorter length alone, and a masked splat followed by a masked add must skip exactly the cleared element. An off-by-one in the length counter would show up in two ways: an element just past `vl` that changes, or a `done` that arrives one cycle early or late. An undefined opcode that disturbed `result` or a register would also be caught.

// File: rtl/vexu_pkg.sv
package vexu_pkg;

  typedef enum logic [3:0] {
    OP_SETVL   = 4'd0,
    OP_ADD_VV  = 4'd1,
    OP_SUB_VV  = 4'd2,
    OP_MUL_VV  = 4'd3,
    OP_ADD_VS  = 4'd4,
    OP_SUB_VS  = 4'd5,
    OP_MUL_VS  = 4'd6,
    OP_CMPNE   = 4'd7,
    OP_SPLAT   = 4'd8,
    OP_INSERT  = 4'd9,
    OP_EXTRACT = 4'd10,
    OP_GETPRED = 4'd11
  } vop_e;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic capture;   // latch the accepted instruction
    logic elemEn;    // process element elemIdx this cycle
    logic setLen;    // update vector length
    logic insert;    // single element write
    logic extract;   // single element read to result
    logic getPred;   // predicate to result
  } strobe_t;

  function automatic logic isElemOp(input logic [3:0] op);
    return (op >= 4'd1) && (op <= 4'd8);
  endfunction

  function automatic logic isVecVec(input logic [3:0] op);
    return (op >= 4'd1) && (op <= 4'd3);
  endfunction

endpackage

// File: rtl/vexu_ctrl.sv
module vexu_ctrl
  import vexu_pkg::*;
#(
  parameter int unsigned MAX_VL = 32,
  parameter int unsigned VL_W   = $clog2(MAX_VL + 1),
  parameter int unsigned IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [3:0]       instOp,
  input  logic [VL_W-1:0]  vl,
  output logic             instReady,
  output logic             done,
  output strobe_t          strobe,
  output logic [IDX_W-1:0] elemIdx
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e           state;
  logic [IDX_W-1:0] cnt;
  logic             doneR;
  logic             accept;
  logic             lastElem;

  assign accept    = instValid && (state == ST_IDLE);
  assign instReady = (state == ST_IDLE);
  assign done      = doneR;
  assign elemIdx   = cnt;
  assign lastElem  = (VL_W'(cnt) == (vl - VL_W'(1)));

  always_comb begin
    strobe         = '0;
    strobe.capture = accept;
    strobe.elemEn  = (state == ST_RUN);
    strobe.setLen  = accept && (instOp == OP_SETVL);
    strobe.insert  = accept && (instOp == OP_INSERT);
    strobe.extract = accept && (instOp == OP_EXTRACT);
    strobe.getPred = accept && (instOp == OP_GETPRED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (isElemOp(instOp) && (vl != '0)) begin
              state <= ST_RUN;
              cnt   <= '0;
            end else begin
              doneR <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (lastElem) begin
            state <= ST_IDLE;
            doneR <= 1'b1;
          end else begin
            cnt <= cnt + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vexu_dp.sv
module vexu_dp
  import vexu_pkg::*;
#(
  parameter int unsigned ELEM_W   = 64,
  parameter int unsigned MAX_VL   = 32,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned VL_W     = $clog2(MAX_VL + 1),
  parameter int unsigned IDX_W    = $clog2(MAX_VL),
  parameter int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic [3:0]        instOp,
  input  logic              instMask,
  input  logic [REG_W-1:0]  instVd,
  input  logic [REG_W-1:0]  instVs1,
  input  logic [REG_W-1:0]  instVs2,
  input  logic [ELEM_W-1:0] instScalar,
  output logic [VL_W-1:0]   vl,
  output logic [ELEM_W-1:0] result
);

  logic [ELEM_W-1:0] vrf [NUM_REGS][MAX_VL];
  logic [MAX_VL-1:0] pred;

  logic [3:0]        opR;
  logic              maskR;
  logic [REG_W-1:0]  vdR, vs1R, vs2R;
  logic [ELEM_W-1:0] scalarR;

  logic [ELEM_W-1:0] opA, opB, aluOut;
  logic              predOk, writeEl, cmpEl;
  logic [VL_W-1:0]   lenReq;
  logic [IDX_W-1:0]  accIdx;

  // instruction latch for multi-cycle element work
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR     <= '0;
      maskR   <= 1'b0;
      vdR     <= '0;
      vs1R    <= '0;
      vs2R    <= '0;
      scalarR <= '0;
    end else if (strobe.capture) begin
      opR     <= instOp;
      maskR   <= instMask;
      vdR     <= instVd;
      vs1R    <= instVs1;
      vs2R    <= instVs2;
      scalarR <= instScalar;
    end
  end

  assign opA = vrf[vs1R][elemIdx];
  assign opB = isVecVec(opR) ? vrf[vs2R][elemIdx] : scalarR;

  always_comb begin
    case (opR)
      OP_ADD_VV, OP_ADD_VS: aluOut = opA + opB;
      OP_SUB_VV, OP_SUB_VS: aluOut = opA - opB;
      OP_MUL_VV, OP_MUL_VS: aluOut = opA * opB;
      default:              aluOut = scalarR;
    endcase
  end

  assign predOk  = !maskR || pred[elemIdx];
  assign writeEl = strobe.elemEn && isElemOp(opR) && (opR != OP_CMPNE) && predOk;
  assign cmpEl   = strobe.elemEn && (opR == OP_CMPNE);
  assign accIdx  = IDX_W'(instVs2);
  assign lenReq  = (instScalar > ELEM_W'(MAX_VL)) ? VL_W'(MAX_VL)
                                                  : instScalar[VL_W-1:0];

  // register file, no reset
  always_ff @(posedge clk) begin
    if (writeEl)
      vrf[vdR][elemIdx] <= aluOut;
    else if (strobe.insert)
      vrf[instVd][accIdx] <= instScalar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pred <= '0;
    else if (cmpEl)
      pred[elemIdx] <= (opA != scalarR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      vl <= VL_W'(MAX_VL);
    else if (strobe.setLen)
      vl <= lenReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      result <= '0;
    else if (strobe.setLen)
      result <= ELEM_W'(lenReq);
    else if (strobe.extract)
      result <= vrf[instVs1][accIdx];
    else if (strobe.getPred)
      result <= ELEM_W'(pred);
  end

endmodule

// File: rtl/masked_vector_unit.sv
module masked_vector_unit
  import vexu_pkg::*;
#(
  parameter int unsigned ELEM_W   = 64,
  parameter int unsigned MAX_VL   = 32,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned VL_W    = $clog2(MAX_VL + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_VL),
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instOp,
  input  logic              instMask,
  input  logic [REG_W-1:0]  instVd,
  input  logic [REG_W-1:0]  instVs1,
  input  logic [REG_W-1:0]  instVs2,
  input  logic [ELEM_W-1:0] instScalar,
  output logic              instReady,
  output logic              done,
  output logic [ELEM_W-1:0] result
);

  strobe_t          strobe;
  logic [IDX_W-1:0] elemIdx;
  logic [VL_W-1:0]  vl;

  vexu_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instOp    (instOp),
    .vl        (vl),
    .instReady (instReady),
    .done      (done),
    .strobe    (strobe),
    .elemIdx   (elemIdx)
  );

  vexu_dp #(
    .ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .NUM_REGS(NUM_REGS),
    .VL_W(VL_W), .IDX_W(IDX_W), .REG_W(REG_W)
  ) dpI (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .elemIdx    (elemIdx),
    .instOp     (instOp),
    .instMask   (instMask),
    .instVd     (instVd),
    .instVs1    (instVs1),
    .instVs2    (instVs2),
    .instScalar (instScalar),
    .vl         (vl),
    .result     (result)
  );

endmodule

// File: rtl/masked_vector_unit_chk.sv
module masked_vector_unit_chk #(
  parameter int unsigned ELEM_W = 64,
  parameter int unsigned MAX_VL = 32,
  parameter int unsigned REG_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [3:0]        instOp,
  input logic              instMask,
  input logic [REG_W-1:0]  instVd,
  input logic [REG_W-1:0]  instVs1,
  input logic [REG_W-1:0]  instVs2,
  input logic [ELEM_W-1:0] instScalar,
  input logic              instReady,
  input logic              done,
  input logic [ELEM_W-1:0] result
);

  // R9
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instReady |-> !done);

  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> instReady);

  // R9
  accept_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> (done || !instReady));

  // R1
  setvl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady && instOp == 4'd0) |=> (done && result <= ELEM_W'(MAX_VL)));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R11
  undef_quick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady && instOp >= 4'd12) |=> done);

endmodule

bind masked_vector_unit masked_vector_unit_chk #(
  .ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .REG_W(REG_W)
) chkI (.*);

// File: tb/masked_vector_unit_test.sv
`timescale 1ns/1ps
module masked_vector_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  instOp = '0;
  logic        instMask = 1'b0;
  logic [4:0]  instVd = '0, instVs1 = '0, instVs2 = '0;
  logic [63:0] instScalar = '0;
  logic        instReady, done;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  masked_vector_unit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instMask(instMask), .instVd(instVd), .instVs1(instVs1), .instVs2(instVs2),
    .instScalar(instScalar), .instReady(instReady), .done(done), .result(result)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1},
    '{4'd2, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF},
    '{4'd3, 64'h1_0000_0001, 64'h1_0000_0001, 64'h2_0000_0001},
    '{4'd4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0},
    '{4'd5, 64'd10, 64'd3, 64'd7},
    '{4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns number of negedges from acceptance until done is seen
  task automatic issue(input logic [3:0] op, input logic m, input logic [4:0] vd,
                       input logic [4:0] s1, input logic [4:0] s2,
                       input logic [63:0] sc, output int cyc, output logic busySeen);
    @(negedge clk);
    while (!instReady) @(negedge clk);
    instOp = op; instMask = m; instVd = vd; instVs1 = s1; instVs2 = s2;
    instScalar = sc; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    cyc = 1;
    busySeen = !instReady;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic op(input logic [3:0] o, input logic m, input logic [4:0] vd,
                    input logic [4:0] s1, input logic [4:0] s2, input logic [63:0] sc);
    int c; logic b;
    issue(o, m, vd, s1, s2, sc, c, b);
  endtask

  task automatic extract(input logic [4:0] v, input logic [4:0] idx, output logic [63:0] val);
    op(4'd10, 1'b0, 5'd0, v, idx, 64'd0);
    val = result;
  endtask

  initial begin
    logic [63:0] v;
    int cyc;
    logic busy;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready", {63'd0, instReady}, 64'd1);
    check("R10 done", {63'd0, done}, 64'd0);
    check("R10 result", result, 64'd0);
    rstN = 1'b1;
    op(4'd11, 0, 0, 0, 0, 0);
    check("R10 pred", result, 64'd0);
    op(4'd8, 0, 5'd5, 0, 0, 64'd7);
    extract(5'd5, 5'd31, v);
    check("R10 vl 32 / R7 splat", v, 64'd7);

    // R1 set length
    op(4'd0, 0, 0, 0, 0, 64'd100);   check("R1 vl 100", result, 64'd32);
    op(4'd0, 0, 0, 0, 0, 64'd5);     check("R1 vl 5", result, 64'd5);
    op(4'd0, 0, 0, 0, 0, 64'd0);     check("R1 vl 0", result, 64'd0);
    op(4'd0, 0, 0, 0, 0, 64'h100_0000_0003); check("R1 vl high", result, 64'd32);
    op(4'd0, 0, 0, 0, 0, 64'd32);    check("R1 vl 32", result, 64'd32);

    // table of arithmetic vectors, vl = 32
    for (int k = 0; k < NVEC; k++) begin
      op(4'd8, 0, 5'd1, 0, 0, VECS[k].a);
      op(4'd8, 0, 5'd2, 0, 0, VECS[k].b);
      op(VECS[k].op, 0, 5'd3, 5'd1, 5'd2, (VECS[k].op >= 4'd4) ? VECS[k].b : 64'd0);
      extract(5'd3, 5'd0, v);
      check((VECS[k].op < 4'd4) ? "R2 vv elem0" : "R3 vs elem0", v, VECS[k].exp);
      extract(5'd3, 5'd31, v);
      check((VECS[k].op < 4'd4) ? "R2 vv elem31" : "R3 vs elem31", v, VECS[k].exp);
    end

    // R8 insert distinct elements, then R3 over all of them
    for (int i = 0; i < 32; i++) op(4'd9, 0, 5'd4, 0, 5'(i), 64'(i * 3));
    op(4'd4, 0, 5'd6, 5'd4, 0, 64'd10);
    for (int i = 0; i < 32; i++) begin
      extract(5'd6, 5'(i), v);
      check("R3 R8 per element", v, 64'(i * 3 + 10));
    end

    // R9 vl = 0: quick done, nothing written
    op(4'd0, 0, 0, 0, 0, 64'd0);
    issue(4'd8, 0, 5'd6, 0, 0, 64'd99, cyc, busy);
    check("R9 vl0 cycles", 64'(cyc), 64'd1);
    op(4'd0, 0, 0, 0, 0, 64'd8);
    extract(5'd6, 5'd0, v);
    check("R9 vl0 no write", v, 64'd10);

    // R9 busy window at vl = 8
    issue(4'd8, 0, 5'd9, 0, 0, 64'd1, cyc, busy);
    check("R9 busy after accept", {63'd0, busy}, 64'd1);
    check("R9 done timing", 64'(cyc), 64'd9);
    @(negedge clk);
    check("R9 done one cycle", {63'd0, done}, 64'd0);

    // R4 compare: full length then shorter length
    op(4'd0, 0, 0, 0, 0, 64'd32);
    op(4'd7, 0, 0, 5'd4, 0, 64'd9);
    op(4'd11, 0, 0, 0, 0, 0);
    check("R4 R8 pred full", result, 64'h0000_0000_FFFF_FFF7);
    op(4'd0, 0, 0, 0, 0, 64'd8);
    op(4'd7, 0, 0, 5'd4, 0, 64'd6);
    op(4'd11, 0, 0, 0, 0, 0);
    check("R4 pred upper kept", result, 64'h0000_0000_FFFF_FFFB);

    // R5 masked splat and masked add
    op(4'd0, 0, 0, 0, 0, 64'd32);
    op(4'd8, 0, 5'd7, 0, 0, 64'd0);
    op(4'd8, 1, 5'd7, 0, 0, 64'd5);
    extract(5'd7, 5'd2, v);  check("R5 masked splat skip", v, 64'd0);
    extract(5'd7, 5'd3, v);  check("R5 R7 masked splat write", v, 64'd5);
    op(4'd1, 1, 5'd7, 5'd4, 5'd7, 64'd0);
    extract(5'd7, 5'd2, v);  check("R5 masked add skip", v, 64'd0);
    extract(5'd7, 5'd4, v);  check("R5 R2 masked add write", v, 64'd17);

    // R6 elements at and above vl untouched
    op(4'd8, 0, 5'd8, 0, 0, 64'd1);
    op(4'd0, 0, 0, 0, 0, 64'd4);
    op(4'd8, 0, 5'd8, 0, 0, 64'd2);
    extract(5'd8, 5'd3, v);  check("R6 below vl", v, 64'd2);
    extract(5'd8, 5'd4, v);  check("R6 at vl", v, 64'd1);

    // R11 undefined opcode
    issue(4'd13, 0, 5'd8, 5'd8, 5'd0, 64'd77, cyc, busy);
    check("R11 cycles", 64'(cyc), 64'd1);
    check("R11 result kept", result, 64'd1);
    extract(5'd8, 5'd0, v);  check("R11 reg kept", v, 64'd2);
    op(4'd11, 0, 0, 0, 0, 0);
    check("R11 pred kept", result, 64'h0000_0000_FFFF_FFFB);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule